// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes into a serial stream in one of two formats. In asynchronous mode it sends each byte as a character frame on a single data line. In synchronous mode it shifts the byte out next to a clock that it drives itself. A holding register accepts the next byte while the shift register is still sending the current one. Software can turn this second buffer on or off.

Bytes arrive on a valid/ready write port. When buffering is on, `wr_ready` is high whenever the holding register is empty. When buffering is off, `wr_ready` is high only when the holding register is empty and the shifter is idle. A byte is taken at a rising clock edge where `wr_valid` and `wr_ready` are both high. A writer that sees `wr_ready` low must keep `wr_valid` and `wr_data` steady until the transfer happens.

All bit timing comes from a one-cycle `baud_tick` strobe. The block reports two status flags: one shows that the holding register has just been emptied into the shifter, and one shows a clock-mode underrun.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `ser_out` is 1, `sclk_out` is 1, `underrun` is 0 and `wr_ready` is 1. With `dbuf_en`=1, `tx_empty` reads 1.
- R2: With `sync_mode`=0, a frame is a start bit of 0, then the 8 data bits LSB first, then the stop bits at 1. Each bit lasts one `baud_tick` period. The line is 1 whenever no frame is being sent.
- R3: With `stop_two`=1 a frame ends with two stop bits, and with `stop_two`=0 it ends with one. The setting is captured when the byte enters the shifter.
- R4: With `sync_mode`=1, each of the 8 bits lasts two tick periods. `sclk_out` is 0 during the first period and 1 during the second, so data is valid at every rising edge of `sclk_out`. `sclk_out` is 1 when idle.
- R5: In synchronous mode, `msb_first`=1 sends bit 7 first and `msb_first`=0 sends bit 0 first. The setting is captured when the byte enters the shifter, so changing it during that byte has no effect on the byte.
- R6: With `dbuf_en`=1, a byte waiting in the holding register when a frame ends starts on that same tick, with no idle bit in between.
- R7: With `dbuf_en`=0, `wr_ready` is 0 while the shifter is busy. A second byte is then accepted only after the frame ends, which leaves one idle tick period between frames.
- R8: With `dbuf_en`=1, `tx_empty` becomes 1 when a byte moves from the holding register into the shifter, and 0 after a byte is accepted. With `dbuf_en`=0, `tx_empty` is held at 0.
- R9: `underrun` is set when a synchronous-mode byte finishes with `dbuf_en`=1 and the holding register empty. It is never set by an asynchronous frame, and never set with `dbuf_en`=0.
- R10: `underrun` stays set until a one-cycle `udr_clr` pulse clears it. A new underrun in the same cycle as `udr_clr` wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A byte is offered on `wr_data` |
| wr_ready | output | 1 | The block can take the offered byte |
| wr_data | input | DATA_W | Byte to send |
| sync_mode | input | 1 | 0 = asynchronous frames, 1 = clocked shift stream |
| stop_two | input | 1 | 1 = two stop bits in asynchronous mode |
| msb_first | input | 1 | 1 = MSB first in synchronous mode |
| dbuf_en | input | 1 | Enables the holding register as a second buffer |
| baud_tick | input | 1 | One-cycle bit-timing strobe |
| udr_clr | input | 1 | Read strobe that clears `underrun` |
| ser_out | output | 1 | Serial data line |
| sclk_out | output | 1 | Shift clock in synchronous mode |
| tx_empty | output | 1 | Holding register emptied into the shifter |
| underrun | output | 1 | Synchronous-mode underrun flag |

## Verification
Asynchronous frames are sent as back-to-back pairs with one and with two stop bits. The spacing between start bits tells the gapless hand-over (10 or 11 ticks) apart from the single-buffer path (11 ticks including an idle bit) and confirms the stop length. Synchronous transfers use the byte 0xB4, whose bit-reversed value is different, so LSB-first and MSB-first order cannot be confused. In one of these transfers the order input is flipped after the byte has loaded, which shows that the setting is captured only at load. The underrun flag is checked after synchronous bytes with buffering on and off, and after asynchronous frames; its clear is checked separately.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic {
    TXM_ASYNC = 1'b0,
    TXM_SYNC  = 1'b1
  } txs_mode_e;
endpackage

// File: rtl/txs_hold.sv
module txs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbuf_en,
  input  logic              shf_active,
  input  logic              take,
  output logic              wr_ready,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_empty
);
  logic accept;
  logic empty_q;

  // With the second buffer off, the holding stage only stages one byte for an idle shifter.
  assign wr_ready = !hold_full && (dbuf_en || !shf_active);
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      empty_q <= 1'b1;
    else if (accept) empty_q <= 1'b0;
    else if (take)   empty_q <= 1'b1;
  end

  assign tx_empty = dbuf_en && empty_q;
endmodule

// File: rtl/txs_shift.sv
module txs_shift
  import txs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              sync_mode,
  input  logic              stop_two,
  input  logic              msb_first,
  output logic              shf_active,
  output logic              take,
  output logic              frame_done,
  output txs_mode_e         mode_q,
  output logic              ser_out,
  output logic              sclk_out
);
  localparam int FW = DATA_W + 3;          // start + data + up to two stops
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0]     shreg;
  logic [CW-1:0]     bits_left;
  logic              phase;
  logic [DATA_W-1:0] rev_data;
  logic [FW-1:0]     async_frame;
  logic [FW-1:0]     sync_frame;
  logic              bit_end;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_data[i] = hold_data[DATA_W-1-i];
  end

  assign async_frame = {2'b11, hold_data, 1'b0};
  assign sync_frame  = {3'b111, (msb_first ? rev_data : hold_data)};

  // Async bits end on every tick; clocked bits end on the tick closing the high half.
  assign bit_end    = baud_tick && shf_active && ((mode_q == TXM_ASYNC) || phase);
  assign frame_done = bit_end && (bits_left == CW'(1));
  assign take       = baud_tick && hold_full && (!shf_active || frame_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_active <= 1'b0;
      phase      <= 1'b0;
      mode_q     <= TXM_ASYNC;
      shreg      <= '1;
      bits_left  <= '0;
    end else if (take) begin
      shf_active <= 1'b1;
      phase      <= 1'b0;
      if (sync_mode) begin
        mode_q    <= TXM_SYNC;
        shreg     <= sync_frame;
        bits_left <= CW'(DATA_W);
      end else begin
        mode_q    <= TXM_ASYNC;
        shreg     <= async_frame;
        bits_left <= stop_two ? CW'(FW) : CW'(FW - 1);
      end
    end else if (frame_done) begin
      shf_active <= 1'b0;
      phase      <= 1'b0;
      shreg      <= '1;
      bits_left  <= '0;
    end else if (bit_end) begin
      shreg     <= {1'b1, shreg[FW-1:1]};
      bits_left <= bits_left - CW'(1);
      phase     <= 1'b0;
    end else if (baud_tick && shf_active) begin
      phase <= 1'b1;
    end
  end

  assign ser_out  = shf_active ? shreg[0] : 1'b1;
  assign sclk_out = !(shf_active && (mode_q == TXM_SYNC) && !phase);
endmodule

// File: rtl/txs_underrun.sv
module txs_underrun
  import txs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_done,
  input  txs_mode_e mode_q,
  input  logic      dbuf_en,
  input  logic      hold_full,
  input  logic      udr_clr,
  output logic      udr_set,
  output logic      underrun
);
  assign udr_set = frame_done && (mode_q == TXM_SYNC) && dbuf_en && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       underrun <= 1'b0;
    else if (udr_set) underrun <= 1'b1;
    else if (udr_clr) underrun <= 1'b0;
  end
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import txs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_mode,
  input  logic              stop_two,
  input  logic              msb_first,
  input  logic              dbuf_en,
  input  logic              baud_tick,
  input  logic              udr_clr,
  output logic              ser_out,
  output logic              sclk_out,
  output logic              tx_empty,
  output logic              underrun
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              shf_active;
  logic              take;
  logic              frame_done;
  logic              udr_set;
  txs_mode_e         mode_q;

  txs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .dbuf_en    (dbuf_en),
    .shf_active (shf_active),
    .take       (take),
    .wr_ready   (wr_ready),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .tx_empty   (tx_empty)
  );

  txs_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .sync_mode  (sync_mode),
    .stop_two   (stop_two),
    .msb_first  (msb_first),
    .shf_active (shf_active),
    .take       (take),
    .frame_done (frame_done),
    .mode_q     (mode_q),
    .ser_out    (ser_out),
    .sclk_out   (sclk_out)
  );

  txs_underrun u_udr (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .mode_q     (mode_q),
    .dbuf_en    (dbuf_en),
    .hold_full  (hold_full),
    .udr_clr    (udr_clr),
    .udr_set    (udr_set),
    .underrun   (underrun)
  );
endmodule

// File: rtl/txs_checker.sv
module txs_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic dbuf_en,
  input logic shf_active,
  input logic hold_full,
  input logic frame_done,
  input logic udr_set,
  input logic udr_clr,
  input logic underrun,
  input logic tx_empty,
  input logic sclk_out,
  input logic ser_out
);
  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shf_active |-> ser_out);

  p_idle_clock_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shf_active |-> sclk_out);

  p_gapless_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && hold_full) |=> shf_active);

  p_single_buf_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbuf_en && shf_active) |-> !wr_ready);

  p_empty_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en |-> !tx_empty);

  p_empty_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && dbuf_en) |=> !tx_empty);

  p_underrun_needs_dbuf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(dbuf_en));

  p_underrun_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_clr && !udr_set) |=> !underrun);

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !udr_clr) |=> underrun);
endmodule

bind dbuf_serial_tx txs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .dbuf_en    (dbuf_en),
  .shf_active (shf_active),
  .hold_full  (hold_full),
  .frame_done (frame_done),
  .udr_set    (udr_set),
  .udr_clr    (udr_clr),
  .underrun   (underrun),
  .tx_empty   (tx_empty),
  .sclk_out   (sclk_out),
  .ser_out    (ser_out)
);

// File: tb/dbuf_serial_tx_test.sv
`timescale 1ns/1ps
module dbuf_serial_tx_test;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic sync_mode = 1'b0, stop_two = 1'b0, msb_first = 1'b0, dbuf_en = 1'b1;
  logic baud_tick = 1'b0;
  logic udr_clr = 1'b0;
  logic ser_out, sclk_out, tx_empty, underrun;

  always #5 clk = ~clk;

  dbuf_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .sync_mode(sync_mode), .stop_two(stop_two),
    .msb_first(msb_first), .dbuf_en(dbuf_en), .baud_tick(baud_tick),
    .udr_clr(udr_clr), .ser_out(ser_out), .sclk_out(sclk_out),
    .tx_empty(tx_empty), .underrun(underrun)
  );

  int div_cnt = 0;
  int tick_cnt = 0;
  always @(negedge clk) begin
    div_cnt   <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
    baud_tick <= (div_cnt == TICK_DIV - 1);
  end
  always @(posedge clk) if (baud_tick) tick_cnt <= tick_cnt + 1;

  typedef struct {
    bit       sync;
    bit       two;
    bit       msb;
    bit [7:0] d;
  } item_t;
  item_t exp_q[$];
  int starts[$];
  int total = 0, bad = 0;
  int seen = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample_tick(output logic b);
    do @(negedge clk); while (tick_cnt == seen);
    seen = tick_cnt;
    b = ser_out;
  endtask

  // Monitor: recover each frame from the pins and compare with the oldest expected item.
  initial begin
    forever begin
      item_t it;
      logic b;
      logic [7:0] got;
      wait (exp_q.size() > 0);
      it = exp_q[0];
      got = '0;
      if (!it.sync) begin
        seen = tick_cnt;
        do sample_tick(b); while (b != 1'b0);
        starts.push_back(tick_cnt);
        for (int i = 0; i < 8; i++) begin
          sample_tick(b);
          got[i] = b;
        end
        check(got == it.d, "R2 async data", got, it.d);
        for (int s = 0; s < (it.two ? 2 : 1); s++) begin
          sample_tick(b);
          check(b == 1'b1, "R3 stop bit", b, 1);
        end
      end else begin
        logic prev;
        prev = sclk_out;
        for (int i = 0; i < 8; i++) begin
          do begin
            @(negedge clk);
            b = (prev == 1'b0) && (sclk_out == 1'b1);
            prev = sclk_out;
          end while (!b);
          if (it.msb) got[7-i] = ser_out;
          else        got[i]   = ser_out;
        end
        check(got == it.d, "R4/R5 sync data and order", got, it.d);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic send(input logic [7:0] d);
    item_t it;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    it.sync = sync_mode; it.two = stop_two; it.msb = msb_first; it.d = d;
    @(negedge clk);
    exp_q.push_back(it);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (4 * TICK_DIV) @(negedge clk);
  endtask

  task automatic next_tick();
    int t;
    t = tick_cnt;
    do @(negedge clk); while (tick_cnt == t);
  endtask

  task automatic clear_udr();
    @(negedge clk); udr_clr = 1'b1;
    @(negedge clk); udr_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ser_out == 1'b1, "R1 line idle", ser_out, 1);
    check(sclk_out == 1'b1, "R1 clock idle", sclk_out, 1);
    check(underrun == 1'b0, "R1 underrun", underrun, 0);
    check(tx_empty == 1'b1, "R1 empty flag", tx_empty, 1);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);

    // R2/R6: async one stop, back-to-back pair
    starts.delete();
    send(8'hA5);
    send(8'h3C);
    drain();
    check(starts.size() == 2 && starts[1] - starts[0] == 10, "R6 gapless, one stop",
          starts[1] - starts[0], 10);
    check(underrun == 1'b0, "R9 no underrun after async", underrun, 0);

    // R3: two stop bits
    stop_two = 1'b1;
    starts.delete();
    send(8'h81);
    send(8'h7E);
    drain();
    check(starts[1] - starts[0] == 11, "R3 two stop spacing", starts[1] - starts[0], 11);
    stop_two = 1'b0;

    // R7/R8: single buffer
    dbuf_en = 1'b0;
    @(negedge clk);
    check(tx_empty == 1'b0, "R8 flag masked without buffer", tx_empty, 0);
    starts.delete();
    send(8'h55);
    next_tick();
    check(wr_ready == 1'b0, "R7 not ready while busy", wr_ready, 0);
    send(8'hC3);
    drain();
    check(starts[1] - starts[0] == 11, "R7 idle bit between frames", starts[1] - starts[0], 11);
    dbuf_en = 1'b1;

    // R8: flag clears on write, sets on move
    send(8'h12);
    check(tx_empty == 1'b0, "R8 clear on write", tx_empty, 0);
    next_tick();
    check(tx_empty == 1'b1, "R8 set on move", tx_empty, 1);
    drain();

    // R4/R5/R9: sync LSB first, lone byte gives underrun
    sync_mode = 1'b1;
    msb_first = 1'b0;
    send(8'hB4);
    drain();
    check(sclk_out == 1'b1, "R4 clock idles high", sclk_out, 1);
    check(underrun == 1'b1, "R9 underrun set", underrun, 1);
    repeat (3) @(negedge clk);
    check(underrun == 1'b1, "R10 underrun sticky", underrun, 1);
    clear_udr();
    check(underrun == 1'b0, "R10 cleared by read", underrun, 0);

    // R5: MSB first, order flipped after load has no effect
    msb_first = 1'b1;
    send(8'hB4);
    next_tick();
    next_tick();
    msb_first = 1'b0;
    drain();
    clear_udr();

    // R9: no underrun with buffering off
    dbuf_en = 1'b0;
    send(8'h6D);
    drain();
    check(underrun == 1'b0, "R9 no underrun without buffer", underrun, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule